// File: doc/BRIEF.md
# DMA Channel Address and Page Unit

This block holds the addressing state of a set of DMA channels. Every channel keeps a 16-bit current address and a 16-bit current count, plus base copies of both. An 8-bit page latch per channel supplies the upper address bits. When a channel is active, its page value and its current address are joined into a 24-bit physical address. Stepping a transfer changes only the low 16 bits, so a transfer that runs past 0xFFFF wraps back to offset 0x0000 of the same 64K region.

A processor programs each 16-bit register through one shared 8-bit data port. A single byte-order flag, common to all channels, decides whether an access hits the low byte or the high byte. A separate clear command resets the flag to the low byte. Reads return the current values through the same port, in the same low-then-high order. The page latches are written through their own port. The sequencer that decides when a transfer happens sits outside this block. It drives `active`, `act_ch` and a one-cycle `step` for each completed transfer.

Top module: `dma_addr_page_unit`

## Requirements
- R1: After reset all address, count and page registers are zero, the byte-order flag selects the low byte, `phys_addr` is zero and `tc` is low.
- R2: Each register write (`reg_wr`) or read (`reg_rd`) toggles one byte-order flag shared by all channels. A write while the flag selects low sets bits 7:0; a write while it selects high sets bits 15:8. `reg_sel` = 0 selects the address and 1 selects the count.
- R3: A one-cycle `ptr_clr` sets the flag to low, so the next access uses the low byte whatever came before.
- R4: A register write updates the selected byte of both the base copy and the current copy of that register.
- R5: `reg_rdata` shows the selected byte of the current address or count of channel `reg_ch` in the same cycle. Which byte it shows follows the byte-order flag.
- R6: While `active` is high, `phys_addr` equals {page of `act_ch`, current address of `act_ch`}. While `active` is low it is zero.
- R7: A `step` while `active` is high adds one to the current address of `act_ch` and subtracts one from its current count. The change is visible in the next cycle.
- R8: A step at current address 0xFFFF gives address 0x0000 and leaves the page unchanged.
- R9: A step taken while the current count is 0x0000 raises `tc` for exactly the following cycle. Without auto-reload the count becomes 0xFFFF.
- R10: When `autoinit[ch]` is set, a step taken at count 0x0000 reloads the current address and current count from the base copies instead of stepping them.
- R11: `page_wr` loads the page latch of `page_ch` only. No other channel's page changes, and steps never change any page.
- R12: A `step` while `active` is low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write one byte of an address or count register |
| reg_rd | input | 1 | Read strobe; advances the byte-order flag |
| reg_ch | input | 2 | Channel addressed by the register port |
| reg_sel | input | 1 | 0 = address, 1 = count |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte |
| ptr_clr | input | 1 | Reset the byte-order flag to low |
| page_wr | input | 1 | Load a page latch |
| page_ch | input | 2 | Channel whose page latch is loaded |
| page_wdata | input | 8 | Page value |
| active | input | 1 | A channel currently owns the bus |
| act_ch | input | 2 | Active channel |
| step | input | 1 | One transfer of the active channel completed |
| autoinit | input | 4 | Per-channel auto-reload enable |
| phys_addr | output | 24 | Page and offset of the active channel |
| tc | output | 1 | Terminal count pulse |

## Verification
The bench walks a transfer across offset 0xFFFF. A design that carried into the page latch would then show the next 64K region instead of offset zero in the same page. It mixes writes to two channels without clearing the flag, and it follows a read with a write. A design that kept a separate flag per channel, or that toggled the flag only on writes, would put bytes in the wrong half. It drives the count through zero with and without auto-reload. An off-by-one terminal count, a `tc` that lasts too long, or a reload of only one of the two registers shows up there. It also steps with `active` low and checks that nothing moved.

// File: rtl/dma_au_pkg.sv
package dma_au_pkg;
    typedef enum logic {
        SEL_ADDR  = 1'b0,
        SEL_COUNT = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic access,
    output logic hi_q
);
    logic hi_d;

    always_comb begin
        hi_d = hi_q;
        if (clr)
            hi_d = 1'b0;
        else if (access)
            hi_d = ~hi_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hi_q <= 1'b0;
        else        hi_q <= hi_d;
    end

    AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !clr) |=> (hi_q != $past(hi_q))); // R2
    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !hi_q); // R3
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_cnt,
    input  logic                  wr_hi,
    input  logic [DATA_W-1:0]     wr_byte,
    input  logic                  page_we,
    input  logic [PAGE_W-1:0]     page_d,
    input  logic                  step_en,
    input  logic                  autoinit,
    output logic [2*DATA_W-1:0]   cur_addr,
    output logic [2*DATA_W-1:0]   cur_cnt,
    output logic [PAGE_W-1:0]     page,
    output logic                  tc_hit
);
    localparam int W = 2 * DATA_W;

    typedef struct packed {
        logic [W-1:0]      base_addr;
        logic [W-1:0]      base_cnt;
        logic [W-1:0]      cur_addr;
        logic [W-1:0]      cur_cnt;
        logic [PAGE_W-1:0] page;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     cnt_zero;

    assign cnt_zero = (st_q.cur_cnt == '0);

    always_comb begin
        st_d = st_q;
        if (step_en) begin
            if (cnt_zero && autoinit) begin
                st_d.cur_addr = st_q.base_addr;
                st_d.cur_cnt  = st_q.base_cnt;
            end else begin
                st_d.cur_addr = st_q.cur_addr + 1'b1;
                st_d.cur_cnt  = st_q.cur_cnt - 1'b1;
            end
        end
        if (wr_en) begin
            if (wr_cnt) begin
                if (wr_hi) begin
                    st_d.base_cnt[W-1:DATA_W] = wr_byte;
                    st_d.cur_cnt[W-1:DATA_W]  = wr_byte;
                end else begin
                    st_d.base_cnt[DATA_W-1:0] = wr_byte;
                    st_d.cur_cnt[DATA_W-1:0]  = wr_byte;
                end
            end else begin
                if (wr_hi) begin
                    st_d.base_addr[W-1:DATA_W] = wr_byte;
                    st_d.cur_addr[W-1:DATA_W]  = wr_byte;
                end else begin
                    st_d.base_addr[DATA_W-1:0] = wr_byte;
                    st_d.cur_addr[DATA_W-1:0]  = wr_byte;
                end
            end
        end
        if (page_we)
            st_d.page = page_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_addr = st_q.cur_addr;
    assign cur_cnt  = st_q.cur_cnt;
    assign page     = st_q.page;
    assign tc_hit   = step_en && cnt_zero;

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !wr_en && !(autoinit && cnt_zero))
        |=> (cur_addr == $past(cur_addr) + 1'b1) && (cur_cnt == $past(cur_cnt) - 1'b1)); // R7
    AST_LOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !wr_en && !(autoinit && cnt_zero) && (cur_addr == '1))
        |=> (cur_addr == '0)); // R8
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !page_we |=> $stable(page)); // R11
    AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !wr_en && autoinit && cnt_zero)
        |=> (cur_addr == $past(st_q.base_addr)) && (cur_cnt == $past(st_q.base_cnt))); // R10
endmodule

// File: rtl/dma_addr_page_unit.sv
module dma_addr_page_unit #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic [$clog2(NUM_CH)-1:0]     reg_ch,
    input  logic                          reg_sel,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    input  logic                          ptr_clr,
    input  logic                          page_wr,
    input  logic [$clog2(NUM_CH)-1:0]     page_ch,
    input  logic [PAGE_W-1:0]             page_wdata,
    input  logic                          active,
    input  logic [$clog2(NUM_CH)-1:0]     act_ch,
    input  logic                          step,
    input  logic [NUM_CH-1:0]             autoinit,
    output logic [PAGE_W+2*DATA_W-1:0]    phys_addr,
    output logic                          tc
);
    import dma_au_pkg::*;

    localparam int CH_W = $clog2(NUM_CH);
    localparam int W    = 2 * DATA_W;

    typedef struct packed {
        logic tc;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic              ptr_hi;
    logic [W-1:0]      addr_a [NUM_CH];
    logic [W-1:0]      cnt_a  [NUM_CH];
    logic [PAGE_W-1:0] page_a [NUM_CH];
    logic [NUM_CH-1:0] tc_hit;
    logic [NUM_CH-1:0] step_v;
    logic [W-1:0]      rd_word;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(reg_sel);

    dma_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ptr_clr),
        .access (reg_wr || reg_rd),
        .hi_q   (ptr_hi)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign step_v[i] = step && active && (act_ch == CH_W'(i));

        dma_chan_regs #(
            .DATA_W (DATA_W),
            .PAGE_W (PAGE_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_wr && (reg_ch == CH_W'(i))),
            .wr_cnt   (sel == SEL_COUNT),
            .wr_hi    (ptr_hi),
            .wr_byte  (reg_wdata),
            .page_we  (page_wr && (page_ch == CH_W'(i))),
            .page_d   (page_wdata),
            .step_en  (step_v[i]),
            .autoinit (autoinit[i]),
            .cur_addr (addr_a[i]),
            .cur_cnt  (cnt_a[i]),
            .page     (page_a[i]),
            .tc_hit   (tc_hit[i])
        );
    end

    always_comb begin
        rd_word   = (sel == SEL_COUNT) ? cnt_a[reg_ch] : addr_a[reg_ch];
        reg_rdata = ptr_hi ? rd_word[W-1:DATA_W] : rd_word[DATA_W-1:0];
        phys_addr = active ? {page_a[act_ch], addr_a[act_ch]} : '0;
        st_d      = st_q;
        st_d.tc   = |tc_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tc = st_q.tc;

    AST_TC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> $past(step && active)); // R9
    AST_ONE_STEPPER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_v)); // R7
    AST_IDLE_NO_TC: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && active) |=> !tc); // R12
endmodule

// File: tb/dma_addr_page_unit_test.sv
module dma_addr_page_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0, ptr_clr = 1'b0;
    logic [1:0]  reg_ch = '0, page_ch = '0, act_ch = '0;
    logic [7:0]  reg_wdata = '0, page_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        page_wr = 1'b0, active = 1'b0, step = 1'b0;
    logic [3:0]  autoinit = '0;
    logic [23:0] phys_addr;
    logic        tc;
    int          checks = 0;
    int          fails = 0;

    always #5 clk = ~clk;

    dma_addr_page_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_ch(reg_ch), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ptr_clr(ptr_clr), .page_wr(page_wr),
        .page_ch(page_ch), .page_wdata(page_wdata), .active(active),
        .act_ch(act_ch), .step(step), .autoinit(autoinit),
        .phys_addr(phys_addr), .tc(tc)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic clr_ptr();
        @(negedge clk); ptr_clr = 1'b1;
        @(negedge clk); ptr_clr = 1'b0;
    endtask

    task automatic wr_byte(input logic [1:0] ch, input logic sel, input logic [7:0] b);
        @(negedge clk); reg_wr = 1'b1; reg_ch = ch; reg_sel = sel; reg_wdata = b;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_byte(input logic [1:0] ch, input logic sel, output logic [7:0] b);
        @(negedge clk); reg_rd = 1'b1; reg_ch = ch; reg_sel = sel;
        #1 b = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wr16(input logic [1:0] ch, input logic sel, input logic [15:0] v);
        clr_ptr();
        wr_byte(ch, sel, v[7:0]);
        wr_byte(ch, sel, v[15:8]);
    endtask

    task automatic rd16(input logic [1:0] ch, input logic sel, output logic [15:0] v);
        logic [7:0] lo, hi;
        clr_ptr();
        rd_byte(ch, sel, lo);
        rd_byte(ch, sel, hi);
        v = {hi, lo};
    endtask

    task automatic set_page(input logic [1:0] ch, input logic [7:0] p);
        @(negedge clk); page_wr = 1'b1; page_ch = ch; page_wdata = p;
        @(negedge clk); page_wr = 1'b0;
    endtask

    task automatic do_step(input logic [1:0] ch, input logic act);
        @(negedge clk); active = act; act_ch = ch; step = 1'b1;
        @(negedge clk); step = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 phys_addr", 32'(phys_addr), 32'h0);
        chk("R1 tc", 32'(tc), 32'h0);
        rd16(2, 1'b0, v);
        chk("R1 addr ch2", 32'(v), 32'h0);
    endtask

    task automatic t_write_order();
        logic [15:0] v;
        wr16(0, 1'b0, 16'h1234);
        rd16(0, 1'b0, v);
        chk("R2 R4 R5 addr ch0", 32'(v), 32'h1234);
        wr16(0, 1'b1, 16'h0002);
        rd16(0, 1'b1, v);
        chk("R4 count ch0", 32'(v), 32'h0002);
    endtask

    task automatic t_shared_ptr();
        logic [15:0] v;
        clr_ptr();
        wr_byte(0, 1'b0, 8'h55);
        wr_byte(1, 1'b0, 8'hAB);
        rd16(1, 1'b0, v);
        chk("R2 shared flag ch1", 32'(v), 32'hAB00);
        rd16(0, 1'b0, v);
        chk("R2 shared flag ch0", 32'(v), 32'h1255);
    endtask

    task automatic t_read_toggles();
        logic [7:0]  b;
        logic [15:0] v;
        clr_ptr();
        rd_byte(0, 1'b0, b);
        chk("R5 low byte first", 32'(b), 32'h55);
        wr_byte(0, 1'b0, 8'h77);
        rd16(0, 1'b0, v);
        chk("R2 read advances flag", 32'(v), 32'h7755);
        clr_ptr();
        wr_byte(0, 1'b0, 8'h10);
        clr_ptr();
        wr_byte(0, 1'b0, 8'h20);
        rd16(0, 1'b0, v);
        chk("R3 clear restarts low", 32'(v), 32'h7720);
    endtask

    task automatic t_page_active();
        set_page(0, 8'h3C);
        set_page(1, 8'h11);
        @(negedge clk); active = 1'b1; act_ch = 2'd0;
        #1 chk("R6 R11 ch0", 32'(phys_addr), 32'h3C7720);
        @(negedge clk); act_ch = 2'd1;
        #1 chk("R6 R11 ch1", 32'(phys_addr), 32'h11AB00);
        @(negedge clk); act_ch = 2'd2;
        #1 chk("R11 ch2 page untouched", 32'(phys_addr), 32'h000000);
        @(negedge clk); active = 1'b0;
        #1 chk("R6 idle", 32'(phys_addr), 32'h0);
    endtask

    task automatic t_step();
        logic [15:0] v;
        wr16(2, 1'b0, 16'h0100);
        wr16(2, 1'b1, 16'h0002);
        set_page(2, 8'h05);
        do_step(2, 1'b1);
        chk("R7 addr step", 32'(phys_addr), 32'h050101);
        rd16(2, 1'b1, v);
        chk("R7 count step", 32'(v), 32'h0001);
        do_step(2, 1'b0);
        rd16(2, 1'b0, v);
        chk("R12 idle step addr", 32'(v), 32'h0101);
        rd16(2, 1'b1, v);
        chk("R12 idle step count", 32'(v), 32'h0001);
    endtask

    task automatic t_wrap();
        wr16(3, 1'b0, 16'hFFFE);
        wr16(3, 1'b1, 16'h0010);
        set_page(3, 8'h7F);
        do_step(3, 1'b1);
        chk("R8 before wrap", 32'(phys_addr), 32'h7FFFFF);
        do_step(3, 1'b1);
        chk("R8 wrap keeps page", 32'(phys_addr), 32'h7F0000);
    endtask

    task automatic t_tc();
        logic [15:0] v;
        wr16(1, 1'b1, 16'h0001);
        do_step(1, 1'b1);
        chk("R9 no tc at count 1", 32'(tc), 32'h0);
        do_step(1, 1'b1);
        chk("R9 tc pulse", 32'(tc), 32'h1);
        @(negedge clk);
        chk("R9 tc one cycle", 32'(tc), 32'h0);
        rd16(1, 1'b1, v);
        chk("R9 count wraps", 32'(v), 32'hFFFF);
        chk("R7 addr after tc", 32'(phys_addr), 32'h11AB02);
    endtask

    task automatic t_autoinit();
        logic [15:0] v;
        autoinit = 4'b0001;
        wr16(0, 1'b0, 16'h2000);
        wr16(0, 1'b1, 16'h0001);
        do_step(0, 1'b1);
        chk("R10 first step", 32'(phys_addr), 32'h3C2001);
        do_step(0, 1'b1);
        chk("R10 tc on reload", 32'(tc), 32'h1);
        chk("R10 addr reloaded", 32'(phys_addr), 32'h3C2000);
        rd16(0, 1'b1, v);
        chk("R10 count reloaded", 32'(v), 32'h0001);
        autoinit = 4'b0000;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_order();
        t_shared_ptr();
        t_read_toggles();
        t_page_active();
        t_step();
        t_wrap();
        t_tc();
        t_autoinit();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule